// File: doc/BRIEF.md
# Masked Sync Pattern Correlator

This block searches a serial PCM bit stream for a frame sync code. It keeps the most recent `WIN_W` recovered bits in a sliding window. Each time a new valid bit arrives, it compares that window with a programmable reference word. A programmable mask marks bit positions as don't-care. The block counts disagreements only over the positions the mask leaves in play. It accepts the window when that count does not exceed a programmable error tolerance.

For every evaluation the block produces two outputs. The first is a one-clock detect strobe. The second is a saturating mismatch count, which a later flywheel or adaptive-strategy stage can use to rank candidate patterns by quality. Reference, mask and tolerance are loaded through a small write port. The bit-enable input lets the window advance only on recovered bits, so the system clock can run faster than the bit rate.

Top module: `sync_correlator`

## Requirements
- R1: Asynchronous active-low reset clears the detect strobe, the mismatch count, the fill state and all three configuration registers (reference 0, mask 0, tolerance 0).
- R2: A write with `cfg_we_i` high loads `cfg_data_i` according to `cfg_sel_i`. Code 0 selects the reference word, code 1 the mask, and code 2 the tolerance (low `TOL_W` bits). A new value is used from the next clock on.
- R3: The window shifts only on clocks where `bit_en_i` is high, and `bit_i` is ignored otherwise. Window position 0 holds the newest bit. Reference bit i is compared with the bit received i enables before the newest one.
- R4: The mismatch count is the number of positions where window and reference differ and the mask bit is 0 (a mask bit of 1 means don't care). The count saturates at 2^`CNT_W`-1.
- R5: A window is accepted when its mismatch count is less than or equal to the tolerance, and the tolerance range covers 0 to 7 errors. Two boundary cases follow: a count exactly equal to the tolerance is accepted, and a count one above it is rejected.
- R6: The window completed by one enabled bit is evaluated at the clock edge of the next enabled bit. At that edge the count updates and the detect strobe is set for that one clock only. Between enabled bits, detect is low and the count holds its value.
- R7: No detect is raised until `WIN_W` bits have been shifted in since reset, so the earliest possible detect comes with enable number `WIN_W`+1.
- R8: A write with `cfg_sel_i` = 3 changes no configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Marks a valid recovered bit on `bit_i` |
| bit_i | input | 1 | Serial data bit |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target: 0 reference, 1 mask, 2 tolerance, 3 none |
| cfg_data_i | input | WIN_W | Configuration write data |
| detect_o | output | 1 | One-clock sync detect strobe |
| err_cnt_o | output | CNT_W | Saturating mismatch count of the last evaluated window |

## Verification
The bench builds the block with a 16-bit window, a 3-bit tolerance and a 4-bit count. With these values, a stream that is the complement of the reference gives 16 mismatches. That value lies above the count's ceiling of 15, so saturation is exercised, and the fill wait before the first detect stays short. The full 0 to 7 tolerance range remains available for the accept and reject boundary words. The same small window lets a long run of randomly gapped enables and mid-stream configuration writes cover many complete window turnovers.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;
  typedef enum logic [1:0] {
    CFG_REF  = 2'd0,
    CFG_MASK = 2'd1,
    CFG_TOL  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs import sync_corr_pkg::*; #(
  parameter int WIN_W = 32,
  parameter int TOL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [WIN_W-1:0] data_i,
  output logic [WIN_W-1:0] ref_o,
  output logic [WIN_W-1:0] mask_o,
  output logic [TOL_W-1:0] tol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o  <= '0;
      mask_o <= '0;
      tol_o  <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        CFG_REF:  ref_o  <= data_i;
        CFG_MASK: mask_o <= data_i;
        CFG_TOL:  tol_o  <= data_i[TOL_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sync_shift_window.sv
module sync_shift_window #(
  parameter int WIN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  output logic [WIN_W-1:0] window_o,
  output logic             full_o
);
  localparam int FILL_W = $clog2(WIN_W + 1);

  logic [FILL_W-1:0] fill_q;

  assign full_o = (fill_q == FILL_W'(WIN_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      window_o <= '0;
      fill_q   <= '0;
    end else if (bit_en_i) begin
      window_o <= {window_o[WIN_W-2:0], bit_i};
      if (!full_o) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_mismatch_count.sv
module sync_mismatch_count #(
  parameter int WIN_W = 32,
  parameter int CNT_W = 4
) (
  input  logic [WIN_W-1:0] window_i,
  input  logic [WIN_W-1:0] ref_i,
  input  logic [WIN_W-1:0] mask_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int SUM_W = $clog2(WIN_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [WIN_W-1:0] diff;
  logic [SUM_W-1:0] sum;

  assign diff = (window_i ^ ref_i) & ~mask_i;

  always_comb begin
    sum = '0;
    for (int i = 0; i < WIN_W; i++) sum = sum + SUM_W'(diff[i]);
  end

  generate
    if (SUM_W > CNT_W) begin : g_sat
      assign count_o = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
    end else begin : g_wide
      assign count_o = CNT_W'(sum);
    end
  endgenerate
endmodule

// File: rtl/sync_correlator.sv
module sync_correlator #(
  parameter int WIN_W = 32,
  parameter int TOL_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             bit_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [WIN_W-1:0] cfg_data_i,
  output logic             detect_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic [WIN_W-1:0] ref_q, mask_q, window;
  logic [TOL_W-1:0] tol_q;
  logic             win_full;
  logic [CNT_W-1:0] mis_cnt;

  sync_cfg_regs #(.WIN_W(WIN_W), .TOL_W(TOL_W)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .data_i (cfg_data_i),
    .ref_o  (ref_q),
    .mask_o (mask_q),
    .tol_o  (tol_q)
  );

  sync_shift_window #(.WIN_W(WIN_W)) i_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .bit_i    (bit_i),
    .window_o (window),
    .full_o   (win_full)
  );

  sync_mismatch_count #(.WIN_W(WIN_W), .CNT_W(CNT_W)) i_cnt (
    .window_i (window),
    .ref_i    (ref_q),
    .mask_i   (mask_q),
    .count_o  (mis_cnt)
  );

  // evaluate the pre-shift window on the following enabled bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      detect_o  <= 1'b0;
      err_cnt_o <= '0;
    end else if (bit_en_i) begin
      detect_o  <= win_full && (mis_cnt <= CNT_W'(tol_q));
      err_cnt_o <= mis_cnt;
    end else begin
      detect_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_correlator_chk.sv
module sync_correlator_chk #(
  parameter int TOL_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic             detect_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic [TOL_W-1:0] tol_q,
  input logic             win_full
);
  assert_det_on_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> $past(bit_en_i));

  assert_err_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_en_i) |-> $stable(err_cnt_o));

  assert_det_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detect_o && !bit_en_i) |=> !detect_o);

  assert_det_within_tol_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> (err_cnt_o <= CNT_W'($past(tol_q))));

  assert_no_early_det_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> $past(win_full));
endmodule

bind sync_correlator sync_correlator_chk #(.TOL_W(TOL_W), .CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_en_i  (bit_en_i),
  .detect_o  (detect_o),
  .err_cnt_o (err_cnt_o),
  .tol_q     (tol_q),
  .win_full  (win_full)
);

// File: tb/test_sync_correlator.sv
module test_sync_correlator;
  localparam int N = 16;
  localparam int TW = 3;
  localparam int CW = 4;
  localparam logic [N-1:0] P = 16'hB38F;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_d = 1'b0, we = 1'b0;
  logic [1:0] sel = '0;
  logic [N-1:0] data = '0;
  logic det;
  logic [CW-1:0] err;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  sync_correlator #(.WIN_W(N), .TOL_W(TW), .CNT_W(CW)) i_sync_correlator (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_d),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_data_i(data),
    .detect_o(det), .err_cnt_o(err)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  bit hist[$];
  int fill, m_tol, exp_err;
  logic [N-1:0] m_ref, m_mask;
  bit exp_det;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < N; i++) hist.push_back(1'b0);
      fill = 0; m_tol = 0; m_ref = '0; m_mask = '0;
      exp_det = 0; exp_err = 0;
    end else begin
      if (bit_en) begin
        int e;
        e = 0;
        for (int i = 0; i < N; i++)
          if (!m_mask[i] && (hist[i] != m_ref[i])) e++;
        exp_err = (e > 15) ? 15 : e;
        exp_det = (fill >= N) && (e <= m_tol);
      end else exp_det = 0;
      if (we) begin
        if (sel == 2'd0) m_ref = data;
        else if (sel == 2'd1) m_mask = data;
        else if (sel == 2'd2) m_tol = int'(data[TW-1:0]);
      end
      if (bit_en) begin
        hist.push_front(bit_d);
        void'(hist.pop_back());
        if (fill < N) fill++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (det !== exp_det || int'(err) !== exp_err) begin
        fails++;
        $display("FAIL %s model: det=%0b err=%0d expected det=%0b err=%0d",
                 cur_req, det, err, exp_det, exp_err);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bit_en = 1'b0; we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [N-1:0] d);
    @(negedge clk); we = 1'b1; sel = s; data = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk); bit_en = 1'b1; bit_d = b;
    @(negedge clk); bit_en = 1'b0; bit_d = $urandom_range(0, 1);
  endtask

  task automatic send_word(input logic [N-1:0] w);
    for (int i = N - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic probe(input string req, input int exp_d, input int exp_e);
    send_bit(1'b0);
    chk(req, int'(det), exp_d);
    chk(req, int'(err), exp_e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    cur_req = "R1";
    chk("R1 detect", int'(det), 0);
    chk("R1 count", int'(err), 0);
    // cleared config: all-zero reference, mask 0, tolerance 0
    send_word('0);
    probe("R1 cleared config", 1, 0);

    // R7: everything don't care, so only fill gates detect
    do_reset();
    cur_req = "R7";
    cfg(2'd1, '1);
    for (int k = 1; k <= N; k++) begin
      send_bit($urandom_range(0, 1));
      chk("R7 before fill", int'(det), 0);
    end
    send_bit(1'b1);
    chk("R7 first full window", int'(det), 1);

    do_reset();
    cur_req = "R2 R5";
    cfg(2'd0, P);
    send_word(P);
    probe("R5 exact match", 1, 0);
    cur_req = "R6";
    @(negedge clk);
    chk("R6 pulse ends", int'(det), 0);
    chk("R6 count held", int'(err), 0);

    cur_req = "R5";
    cfg(2'd2, 16'd3);
    send_word(P ^ 16'h0007);
    probe("R5 count equals tolerance", 1, 3);
    send_word(P ^ 16'h000F);
    probe("R5 one above tolerance", 0, 4);
    cfg(2'd2, 16'd7);
    send_word(P ^ 16'h007F);
    probe("R5 tolerance 7 accepted", 1, 7);
    send_word(P ^ 16'h00FF);
    probe("R5 tolerance 7 exceeded", 0, 8);

    cur_req = "R8";
    cfg(2'd3, '1);
    send_word(P ^ 16'h00FF);
    probe("R8 sel 3 ignored", 0, 8);

    cur_req = "R4";
    cfg(2'd2, 16'd0);
    cfg(2'd1, 16'h00F0);
    send_word(P ^ 16'h00F0);
    probe("R4 masked errors", 1, 0);
    send_word(P ^ 16'h01F0);
    probe("R4 unmasked error", 0, 1);
    cfg(2'd1, 16'h0000);
    send_word(~P);
    probe("R4 saturation", 0, 15);

    cur_req = "R3";
    send_word(P);
    repeat (6) begin
      @(negedge clk); bit_d = ~bit_d;
    end
    probe("R3 no shift without enable", 1, 0);
    send_word(P << 1);
    probe("R3 shifted pattern rejected", 0, int'($countones((P << 1) ^ P)));

    cur_req = "R2 R3 R6 random";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      bit_en = ($urandom_range(0, 2) != 0);
      bit_d = $urandom_range(0, 1);
      we = ($urandom_range(0, 40) == 0);
      sel = 2'($urandom_range(0, 3));
      data = ($urandom_range(0, 1) != 0) ? P ^ N'($urandom_range(0, 15)) : N'($urandom);
    end
    @(negedge clk); bit_en = 1'b0; we = 1'b0;

    cur_req = "R1 mid-run";
    do_reset();
    chk("R1 mid-run reset detect", int'(det), 0);
    chk("R1 mid-run reset count", int'(err), 0);
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule